// File: doc/BRIEF.md
# Double-Buffered Serial Flag Pins

This block controls two general-purpose flag pins that sit beside a synchronous serial transmitter and receiver. Each pin is set as an input or an output. Flag values pass through a two-stage latch in each direction, so they change only at the boundaries of serial data words and stay aligned with the words they go with.

In the input direction, the pin is sampled into a holding stage when the receiver samples the first bit of a word. The held value is then copied into a status bit when the complete received word is transferred to the receive data register. In the output direction, the software-written flag bit is staged when the transmit data register is loaded into the shift register. The staged value reaches the pin when the first bit of that word is sent. The serial engine drives four single-cycle strobes that pace these steps. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure. Strobes are plain one-cycle pulses and are never held off.

Top module: `serial_flag_pins`

## Requirements
- R1: After reset, `pin_oe`, `pin_out` and `flag_status` are all 0.
- R2: While `sync_mode` is 0, neither pin is output-enabled and neither pin is captured as an input flag.
- R3: Flag 0 is active only while `tx1_enable` is 0; while `tx1_enable` is 1, `pin_oe[0]` is 0 and pin 0 is not captured.
- R4: Flag 1 is active only while `tx2_enable` is 0 and `flag1_is_drive_en` is 0; otherwise `pin_oe[1]` is 0 and pin 1 is not captured.
- R5: For an active flag, `flag_dir[i]` = 1 selects output and 0 selects input. A change in direction or enable shows on `pin_oe` one clock later.
- R6: An active input flag is captured when `rx_first_bit` pulses, after its two-flop synchronizer. Later pin changes have no effect until the next `rx_first_bit`.
- R7: On `rx_word_latched`, `flag_status` takes the held input values and keeps them until the next `rx_word_latched`.
- R8: `out_flag` bits are staged only on `tx_word_loaded`. Writes at other times do not reach the pin until a later load and send.
- R9: `pin_out[i]` of an active output flag changes only on `tx_first_bit`, and then takes the staged value.
- R10: `pin_out[i]` is 0 whenever `pin_oe[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | Synchronous serial mode selected |
| flag_dir | input | 2 | Per-flag direction, 1 = output |
| tx1_enable | input | 1 | Transmitter 1 enabled (blocks flag 0) |
| tx2_enable | input | 1 | Transmitter 2 enabled (blocks flag 1) |
| flag1_is_drive_en | input | 1 | Pin 1 assigned as transmitter 0 drive-enable |
| out_flag | input | 2 | Software-written output flag bits |
| rx_first_bit | input | 1 | Strobe: first bit of received word sampled |
| rx_word_latched | input | 1 | Strobe: received word moved to data register |
| tx_word_loaded | input | 1 | Strobe: transmit data moved to shift register |
| tx_first_bit | input | 1 | Strobe: first bit of transmit word sent |
| pin_in | input | 2 | Pin levels from the pads (asynchronous) |
| pin_out | output | 2 | Pin drive values |
| pin_oe | output | 2 | Pin output enables |
| flag_status | output | 2 | Input flag status bits |

## Verification
The hardest situation to reach from the ports is a pin that changes after it has been captured but before the status copy. The stimulus captures a level, flips the pin, lets the new level pass the synchronizer, and only then pulses `rx_word_latched`, so a status update that takes the live pin would show up. Disabled lanes are shown not to capture by the same sequence run with a lane off. A later status copy with no new capture must still report the old held value.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int NUM_FLAGS = 2;

  typedef struct packed {
    logic rx_first;
    logic rx_word;
    logic tx_load;
    logic tx_first;
  } sflag_strobe_t;
endpackage

// File: rtl/sflag_sync.sv
module sflag_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sflag_enable.sv
module sflag_enable
  import sflag_pkg::*;
(
  input  logic                 sync_mode,
  input  logic                 tx1_enable,
  input  logic                 tx2_enable,
  input  logic                 flag1_is_drive_en,
  output logic [NUM_FLAGS-1:0] lane_en
);
  always_comb begin
    lane_en    = '0;
    lane_en[0] = sync_mode & ~tx1_enable;
    lane_en[1] = sync_mode & ~tx2_enable & ~flag1_is_drive_en;
  end
endmodule

// File: rtl/sflag_lane.sv
module sflag_lane
  import sflag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_en,
  input  logic          dir_out,
  input  logic          pin_sync,
  input  logic          of_bit,
  input  sflag_strobe_t strb,
  output logic          status_bit,
  output logic          pin_out,
  output logic          pin_oe
);
  logic in_hold_q, status_q;
  logic out_stage_q, out_drive_q;
  logic oe_q;
  logic capture_in;

  assign capture_in = strb.rx_first & lane_en & ~dir_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold_q <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      if (capture_in)   in_hold_q <= pin_sync;
      if (strb.rx_word) status_q  <= in_hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stage_q <= 1'b0;
      out_drive_q <= 1'b0;
    end else begin
      if (strb.tx_load)  out_stage_q <= of_bit;
      if (strb.tx_first) out_drive_q <= out_stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= lane_en & dir_out;
  end

  assign status_bit = status_q;
  assign pin_oe     = oe_q;
  assign pin_out    = oe_q & out_drive_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rx_first |=> $stable(in_hold_q));
  // R7
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rx_word |=> $stable(status_q));
  // R8
  stage_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.tx_load |=> $stable(out_stage_q));
  // R9
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.tx_first |=> $stable(out_drive_q));
  // R3
  lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> !pin_oe);
  // R10
  always_comb begin
    gated_out_chk: assert (pin_oe || !pin_out);
  end
endmodule

// File: rtl/serial_flag_pins.sv
module serial_flag_pins
  import sflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic [1:0] flag_dir,
  input  logic       tx1_enable,
  input  logic       tx2_enable,
  input  logic       flag1_is_drive_en,
  input  logic [1:0] out_flag,
  input  logic       rx_first_bit,
  input  logic       rx_word_latched,
  input  logic       tx_word_loaded,
  input  logic       tx_first_bit,
  input  logic [1:0] pin_in,
  output logic [1:0] pin_out,
  output logic [1:0] pin_oe,
  output logic [1:0] flag_status
);
  logic [NUM_FLAGS-1:0] lane_en;
  logic [NUM_FLAGS-1:0] pin_sync;
  sflag_strobe_t        strb;

  assign strb = '{rx_first: rx_first_bit, rx_word: rx_word_latched,
                  tx_load: tx_word_loaded, tx_first: tx_first_bit};

  sflag_enable u_enable (
    .sync_mode         (sync_mode),
    .tx1_enable        (tx1_enable),
    .tx2_enable        (tx2_enable),
    .flag1_is_drive_en (flag1_is_drive_en),
    .lane_en           (lane_en)
  );

  sflag_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_FLAGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_lane
      sflag_lane u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_en    (lane_en[i]),
        .dir_out    (flag_dir[i]),
        .pin_sync   (pin_sync[i]),
        .of_bit     (out_flag[i]),
        .strb       (strb),
        .status_bit (flag_status[i]),
        .pin_out    (pin_out[i]),
        .pin_oe     (pin_oe[i])
      );
    end
  endgenerate

  // R2
  async_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> (pin_oe == 2'b00));
  // R4
  flag1_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx2_enable || flag1_is_drive_en) |=> !pin_oe[1]);
endmodule

// File: tb/serial_flag_pins_bench.sv
module serial_flag_pins_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, tx1_enable = 1'b0, tx2_enable = 1'b0, flag1_is_drive_en = 1'b0;
  logic [1:0] flag_dir = 2'b00, out_flag = 2'b00, pin_in = 2'b00;
  logic rx_first_bit = 1'b0, rx_word_latched = 1'b0, tx_word_loaded = 1'b0, tx_first_bit = 1'b0;
  logic [1:0] pin_out, pin_oe, flag_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [5:0] exp_q [$];
  string      req_q [$];
  event       sample_ev;

  always #2 clk = ~clk;

  serial_flag_pins u_serial_flag_pins (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .flag_dir(flag_dir),
    .tx1_enable(tx1_enable), .tx2_enable(tx2_enable),
    .flag1_is_drive_en(flag1_is_drive_en), .out_flag(out_flag),
    .rx_first_bit(rx_first_bit), .rx_word_latched(rx_word_latched),
    .tx_word_loaded(tx_word_loaded), .tx_first_bit(tx_first_bit),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .flag_status(flag_status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [1:0] oe,
                            input logic [1:0] po, input logic [1:0] st);
    exp_q.push_back({oe, po, st});
    req_q.push_back(req);
    -> sample_ev;
    #0.5;
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [5:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if ({pin_oe, pin_out, flag_status} !== e) begin
          failures++;
          $display("FAIL %s: oe/out/status actual=%b/%b/%b expected=%b/%b/%b",
                   r, pin_oe, pin_out, flag_status, e[5:4], e[3:2], e[1:0]);
        end
      end
    end
  end

  task automatic pulse_rx_first();   rx_first_bit = 1'b1;    tick(1); rx_first_bit = 1'b0;    endtask
  task automatic pulse_rx_word();    rx_word_latched = 1'b1; tick(1); rx_word_latched = 1'b0; endtask
  task automatic pulse_tx_load();    tx_word_loaded = 1'b1;  tick(1); tx_word_loaded = 1'b0;  endtask
  task automatic pulse_tx_first();   tx_first_bit = 1'b1;    tick(1); tx_first_bit = 1'b0;    endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_out("R1", 2'b00, 2'b00, 2'b00);
    rst_n = 1'b1;
    tick(2);
    expect_out("R1", 2'b00, 2'b00, 2'b00);

    // flag 0 output, flag 1 input
    sync_mode = 1'b1; flag_dir = 2'b01;
    tick(1);
    expect_out("R5", 2'b01, 2'b00, 2'b00);

    out_flag = 2'b01; tick(2);
    expect_out("R8", 2'b01, 2'b00, 2'b00);
    pulse_tx_load();
    out_flag = 2'b00;
    expect_out("R9", 2'b01, 2'b00, 2'b00);
    pulse_tx_first();
    expect_out("R9", 2'b01, 2'b01, 2'b00);

    // input capture on flag 1, then pin changes before status copy
    pin_in = 2'b10; tick(3);
    pulse_rx_first();
    pin_in = 2'b00; tick(3);
    expect_out("R7", 2'b01, 2'b01, 2'b00);
    pulse_rx_word();
    expect_out("R6", 2'b01, 2'b01, 2'b10);
    pulse_rx_first();
    expect_out("R7", 2'b01, 2'b01, 2'b10);
    pulse_rx_word();
    expect_out("R7", 2'b01, 2'b01, 2'b00);

    // flag 1 claimed as drive-enable
    flag_dir = 2'b11; flag1_is_drive_en = 1'b1; tick(1);
    expect_out("R4", 2'b01, 2'b01, 2'b00);
    out_flag = 2'b10;
    pulse_tx_load(); pulse_tx_first();
    expect_out("R10", 2'b01, 2'b00, 2'b00);
    flag1_is_drive_en = 1'b0; tick(1);
    expect_out("R4", 2'b11, 2'b10, 2'b00);

    tx1_enable = 1'b1; tick(1);
    expect_out("R3", 2'b10, 2'b10, 2'b00);

    // leave synchronous mode: no drive, no capture
    sync_mode = 1'b0; tick(1);
    expect_out("R2", 2'b00, 2'b00, 2'b00);
    flag_dir = 2'b00; pin_in = 2'b11; tick(3);
    pulse_rx_first(); pulse_rx_word();
    expect_out("R2", 2'b00, 2'b00, 2'b00);
    sync_mode = 1'b1; tx1_enable = 1'b0; tick(1);
    pulse_rx_word();
    expect_out("R2", 2'b00, 2'b00, 2'b00);

    pulse_rx_first(); pulse_rx_word();
    expect_out("R6", 2'b00, 2'b00, 2'b11);

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule